// File: doc/BRIEF.md
# Latency-Absorbing Pipeline Output Buffer

The block moves 8-bit words through a fixed-latency processing pipeline whose registers never stall, and collects whatever leaves the pipeline in an output FIFO. Each pipeline stage carries a valid flag beside its word, so gaps in the input stream travel through as empty slots and are never stored. The arithmetic of a real pipeline is replaced here by a plain delay line of `N` stages.

Back-pressure comes only from the FIFO. Its almost-full flag, registered, becomes the upstream busy output. The threshold leaves enough free entries for every word already inside the pipeline, plus one more for the busy register, so nothing in flight is lost. The FIFO drains one word per cycle whenever downstream is not busy, and the word is presented on a registered output. A word offered upstream while busy is high is discarded and raises a sticky error flag.

Top module: `lat_absorb_buf`

## Requirements
- R1: While and right after reset, `busy_o`, `out_valid_o` and `err_o` are low, the FIFO is empty and all stage valid flags are clear.
- R2: Every accepted word leaves exactly once, unchanged, and in the order it was accepted.
- R3: With the FIFO empty and `busy_i` low, a word sampled at a rising edge is shown with `out_valid_o` high in the cycle after the (N+2)th rising edge, counting the sampling edge as the first (N pipeline stages, one FIFO write, one output register).
- R4: Input cycles with `in_valid_i` low occupy no FIFO entry and produce equal gaps at the output when the FIFO is otherwise empty.
- R5: The pipeline advances every cycle regardless of `busy_i`, so words accepted while downstream is busy are already in the FIFO on release and leave on consecutive cycles.
- R6: `out_valid_o` is high in a cycle only if `busy_i` was low at the preceding rising edge; while `busy_i` stays high no word is presented.
- R7: `busy_o` is high in the cycle after an edge where the FIFO holds at least DEPTH-N-1 words; from empty with `busy_i` held high and valid offered every non-busy cycle, exactly DEPTH words are accepted.
- R8: The FIFO never overflows; all DEPTH words accepted in the R7 case are delivered after release.
- R9: A word offered while `busy_o` is high is dropped, never appears at the output, and sets `err_o`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Upstream word |
| in_valid_i | input | 1 | Upstream word valid |
| busy_o | output | 1 | Upstream must hold off (registered almost-full) |
| out_data_o | output | 8 | Downstream word |
| out_valid_o | output | 1 | Downstream word valid, one word per high cycle |
| busy_i | input | 1 | Downstream cannot take a word |
| err_o | output | 1 | Sticky flag: a word was offered while busy |

## Verification
The hardest case is the exact fill limit: the FIFO must reach its threshold while the pipeline is completely full, so that the in-flight words land in the last free entries. The bench holds downstream busy from an empty state and offers a word on every cycle in which busy is low, counting acceptances; this drives the FIFO to exactly full and checks that all words emerge back to back and in order on release. The drop path is reached from the same full state by offering one marked word while busy is high.

// File: rtl/lab_pkg.sv
package lab_pkg;
  localparam int WORD_W = 8;
  typedef logic [WORD_W-1:0] word_t;
  typedef struct packed {
    logic  vld;
    word_t dat;
  } slot_t;
endpackage

// File: rtl/lab_delay_line.sv
module lab_delay_line
  import lab_pkg::*;
#(
  parameter int N = 10
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  slot_t in_i,
  output slot_t out_o
);
  slot_t stg_q [N];

  for (genvar i = 0; i < N; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= in_i;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign out_o = stg_q[N-1];

  // R5
  stage_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_i.vld |=> stg_q[0].vld && stg_q[0].dat == $past(in_i.dat));
endmodule

// File: rtl/lab_fifo.sv
module lab_fifo
  import lab_pkg::*;
#(
  parameter int DEPTH = 20,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  word_t         wdata_i,
  input  logic          rd_i,
  output word_t         rdata_o,
  output logic [CW-1:0] count_o
);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  word_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= (wr_ptr_q == LAST_P) ? '0 : wr_ptr_q + 1'b1;
      if (rd_i) rd_ptr_q <= (rd_ptr_q == LAST_P) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem[rd_ptr_q];
  assign count_o = cnt_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i) |-> cnt_q != FULL_C);
  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> cnt_q != '0);
endmodule

// File: rtl/lat_absorb_buf.sv
module lat_absorb_buf
  import lab_pkg::*;
#(
  parameter int N     = 10,
  parameter int DEPTH = 2 * N
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  output logic       busy_o,
  output logic [7:0] out_data_o,
  output logic       out_valid_o,
  input  logic       busy_i,
  output logic       err_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] THR_C = CW'(DEPTH - N - 1);

  if (DEPTH < 2 * N) begin : g_bad_depth
    $error("DEPTH must be at least 2*N");
  end

  slot_t         pipe_in, pipe_out;
  word_t         fifo_rdata;
  logic [CW-1:0] fill;
  logic          busy_q, err_q, ovld_q, rd_en;
  word_t         odat_q;

  // words offered while busy are discarded
  assign pipe_in.vld = in_valid_i & ~busy_q;
  assign pipe_in.dat = in_data_i;
  assign rd_en       = ~busy_i & (fill != '0);

  lab_delay_line #(.N(N)) i_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (pipe_in),
    .out_o  (pipe_out)
  );

  lab_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (pipe_out.vld),
    .wdata_i (pipe_out.dat),
    .rd_i    (rd_en),
    .rdata_o (fifo_rdata),
    .count_o (fill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      ovld_q <= 1'b0;
      odat_q <= '0;
    end else begin
      busy_q <= (fill >= THR_C);
      if (in_valid_i && busy_q) err_q <= 1'b1;
      ovld_q <= rd_en;
      if (rd_en) odat_q <= fifo_rdata;
    end
  end

  assign busy_o      = busy_q;
  assign err_o       = err_q;
  assign out_valid_o = ovld_q;
  assign out_data_o  = odat_q;

  // R6
  out_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(!busy_i));
  // R7
  busy_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> fill <= THR_C);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R9
  drop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && busy_o) |=> err_o);
endmodule

// File: tb/test_lat_absorb_buf.sv
`timescale 1ns/1ps
module test_lat_absorb_buf;
  localparam int N     = 10;
  localparam int DEPTH = 2 * N;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_valid_i = 1'b0;
  logic       busy_i = 1'b0;
  logic       busy_o, out_valid_o, err_o;
  logic [7:0] out_data_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [7:0] rx_q [$];
  int         rx_cyc [$];

  lat_absorb_buf #(.N(N), .DEPTH(DEPTH)) i_lat_absorb_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_data_i   (in_data_i),
    .in_valid_i  (in_valid_i),
    .busy_o      (busy_o),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .busy_i      (busy_i),
    .err_o       (err_o)
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=%0d exp=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      rx_q.push_back(out_data_o);
      rx_cyc.push_back(cyc);
    end
  end

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; in_valid_i = 1'b0; busy_i = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    step();
    rx_q.delete(); rx_cyc.delete();
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    step();
    check("R1 busy_o in reset", busy_o, 0);
    check("R1 out_valid_o in reset", out_valid_o, 0);
    check("R1 err_o in reset", err_o, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < N + 4; i++) step();
    check("R1 no output after reset", rx_q.size(), 0);
    check("R1 busy_o after reset", busy_o, 0);
  endtask

  task automatic t_latency();
    int c;
    do_reset();
    c = cyc;
    in_data_i = 8'h5A; in_valid_i = 1'b1;
    step();
    in_valid_i = 1'b0;
    for (int i = 0; i < N + 6; i++) step();
    check("R3 one word out", rx_q.size(), 1);
    if (rx_q.size() == 1) begin
      check("R3 data", rx_q[0], 8'h5A);
      check("R3 latency", rx_cyc[0] - c, N + 2);
    end
  endtask

  task automatic t_bubbles();
    do_reset();
    in_data_i = 8'h11; in_valid_i = 1'b1; step();
    in_valid_i = 1'b0; step(); step();
    in_data_i = 8'h22; in_valid_i = 1'b1; step();
    in_valid_i = 1'b0;
    for (int i = 0; i < N + 8; i++) step();
    check("R4 word count", rx_q.size(), 2);
    if (rx_q.size() == 2) begin
      check("R4 gap kept", rx_cyc[1] - rx_cyc[0], 3);
      check("R2 order first", rx_q[0], 8'h11);
      check("R2 order second", rx_q[1], 8'h22);
    end
  endtask

  // fill from empty with downstream busy; returns accepted count
  task automatic fill_busy(output int acc);
    acc = 0;
    busy_i = 1'b1;
    step();
    for (int i = 0; i < 3 * DEPTH; i++) begin
      if (!busy_o) begin
        in_data_i = 8'(acc + 1); in_valid_i = 1'b1; acc++;
      end else in_valid_i = 1'b0;
      step();
    end
    in_valid_i = 1'b0;
  endtask

  task automatic t_backpressure();
    int acc;
    do_reset();
    fill_busy(acc);
    check("R7 accepted words", acc, DEPTH);
    check("R7 busy_o held", busy_o, 1);
    check("R6 nothing out while busy_i", rx_q.size(), 0);
    busy_i = 1'b0;
    for (int i = 0; i < DEPTH + 6; i++) step();
    check("R8 all words out", rx_q.size(), DEPTH);
    if (rx_q.size() == DEPTH) begin
      check("R5 back to back", rx_cyc[DEPTH-1] - rx_cyc[0], DEPTH - 1);
      for (int i = 0; i < DEPTH; i++) check("R2 order", rx_q[i], i + 1);
    end
    check("R7 busy_o released", busy_o, 0);
    check("R9 no error on legal use", err_o, 0);
  endtask

  task automatic t_pause();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      in_data_i = 8'(8'h40 + i); in_valid_i = 1'b1; step();
    end
    in_valid_i = 1'b0;
    for (int i = 0; i < N; i++) step();
    busy_i = 1'b1;
    for (int i = 0; i < 6; i++) step();
    check("R6 pause holds output", rx_q.size() < 4, 1);
    busy_i = 1'b0;
    for (int i = 0; i < 8; i++) step();
    check("R2 pause word count", rx_q.size(), 4);
    if (rx_q.size() == 4)
      for (int i = 0; i < 4; i++) check("R2 pause order", rx_q[i], 8'h40 + i);
  endtask

  task automatic t_drop();
    int acc;
    bit seen;
    do_reset();
    fill_busy(acc);
    in_data_i = 8'hEE; in_valid_i = 1'b1;
    step();
    in_valid_i = 1'b0;
    check("R9 err_o set", err_o, 1);
    busy_i = 1'b0;
    for (int i = 0; i < DEPTH + N + 6; i++) step();
    check("R9 dropped word absent, count", rx_q.size(), DEPTH);
    seen = 1'b0;
    foreach (rx_q[i]) if (rx_q[i] == 8'hEE) seen = 1'b1;
    check("R9 marked word not delivered", seen, 0);
    check("R9 err_o sticky", err_o, 1);
    rst_ni = 1'b0;
    step();
    check("R1 reset clears err_o", err_o, 0);
    rst_ni = 1'b1;
    step();
  endtask

  initial begin
    t_reset();
    t_latency();
    t_bubbles();
    t_backpressure();
    t_pause();
    t_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule